// File: doc/BRIEF.md
# Interrupt Pending and Claim Core

This core holds the arbitration state of a platform interrupt controller that serves several targets, called contexts. Every interrupt source is a level input. The core keeps one pending bit and one claimed bit for each source. Each context has its own enable mask and a priority threshold. A register file outside the core supplies the per-source priorities, the enable masks and the thresholds over plain parallel buses.

Each context drives one registered request line. The line is high while at least one source qualifies for that context. A target claims through a single shared claim port. The port names a context and returns, in the same cycle, the lowest-numbered source that qualifies for that context. At the next clock edge the core records that source as claimed. A target ends service through a complete port, which releases the claimed bit.

Source ID 0 stands for "no interrupt". Input bit 0 is therefore ignored. Bus decoding, edge gateways and trap handling belong to other blocks.

Top module: `intr_claim_core`

## Requirements
- R1: At each clock edge, the pending bit of source i (i >= 1) takes the value of `srcLevel[i]`. Source 0 never becomes pending, whatever its input.
- R2: Source i qualifies for context c when all four of these hold: it is pending, it is not claimed, `ctxEnable[c*NUM_SRC+i]` is 1, and its priority `srcPrio[i*3 +: 3]` is strictly greater than the threshold `ctxThresh[c*3 +: 3]`. A source with priority equal to the threshold does not qualify.
- R3: `irqOut[c]` is a register. It is high in the cycle after a cycle in which any source qualified for context c, and low otherwise. After a level rises, the request therefore appears two clock edges later.
- R4: While `claimReq` is high, `claimId` combinationally shows the lowest-indexed source that qualifies for context `claimCtx`, even when a higher-priority source also qualifies.
- R5: A claim that returns a nonzero ID takes effect at the next edge. It sets the claimed bit of that source and clears its pending bit, overriding the input level for that edge. From the following edge on, the level is sampled again.
- R6: A claim with no qualifying source returns 0 and changes no pending or claimed state.
- R7: A complete with `completeId` below NUM_SRC clears that source's claimed bit at the next edge. A `completeId` at or above NUM_SRC has no effect.
- R8: Reset clears all pending bits, all claimed bits and every request output.
- R9: Priorities and thresholds are 3 bits wide. A priority-0 source never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | NUM_SRC | Level of each interrupt source |
| srcPrio | input | NUM_SRC*3 | Priority of source i in bits [i*3 +: 3] |
| ctxEnable | input | NUM_CTX*NUM_SRC | Enable of source i for context c in bit c*NUM_SRC+i |
| ctxThresh | input | NUM_CTX*3 | Threshold of context c in bits [c*3 +: 3] |
| claimReq | input | 1 | Claim strobe |
| claimCtx | input | CTX_W | Context that is claiming |
| claimId | output | ID_W | Claimed source ID, 0 when none qualifies |
| completeReq | input | 1 | Complete strobe |
| completeId | input | ID_W | Source ID being completed |
| irqOut | output | NUM_CTX | Registered request line per context |

## Verification
The claim result and the request line are tried with four kinds of level pattern: one low source, a group of high-numbered sources, a sparse enable mask, and a mix in which a low-numbered source has low priority and a high-numbered one has high priority. These patterns separate lowest-index selection from highest-priority selection, and a strict threshold comparison from a non-strict one. Directed sequences then check the rest. They cover a claim masking its source from a second context, completes inside and outside the ID range, an empty claim followed by a threshold drop, a level falling while its source is claimed, and the two-edge delay from a level rising to the request line.

// File: rtl/intr_core_pkg.sv
package intr_core_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic claimFire;
    logic completeFire;
  } core_strobe_t;
endpackage

// File: rtl/intr_core_dp.sv
module intr_core_dp #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_SRC-1:0]           srcLevel,
  input  logic [NUM_SRC*PRIO_W-1:0]    srcPrio,
  input  logic [NUM_CTX*NUM_SRC-1:0]   ctxEnable,
  input  logic [NUM_CTX*PRIO_W-1:0]    ctxThresh,
  input  intr_core_pkg::core_strobe_t  strobe,
  input  logic [IDX_W-1:0]             claimIdx,
  input  logic [IDX_W-1:0]             completeIdx,
  output logic [NUM_CTX*NUM_SRC-1:0]   qualify,
  output logic [NUM_CTX-1:0]           irqOut,
  output logic [NUM_SRC-1:0]           pendingVec,
  output logic [NUM_SRC-1:0]           claimedVec
);
  logic [NUM_SRC-1:0] setMask, clrMask, levelMask;

  always_comb begin
    setMask = '0;
    clrMask = '0;
    if (strobe.claimFire)    setMask[claimIdx]    = 1'b1;
    if (strobe.completeFire) clrMask[completeIdx] = 1'b1;
    levelMask = srcLevel;
    levelMask[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingVec <= '0;
      claimedVec <= '0;
    end else begin
      pendingVec <= levelMask & ~setMask;
      claimedVec <= (claimedVec | setMask) & ~clrMask;
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign qualify[c*NUM_SRC+i] = pendingVec[i] & ~claimedVec[i] &
                                    ctxEnable[c*NUM_SRC+i] &
                                    (srcPrio[i*PRIO_W +: PRIO_W] > ctxThresh[c*PRIO_W +: PRIO_W]);
    end
    always_ff @(posedge clk) begin
      if (!rstN) irqOut[c] <= 1'b0;
      else       irqOut[c] <= |qualify[c*NUM_SRC +: NUM_SRC];
    end
  end
endmodule

// File: rtl/intr_core_ctrl.sv
module intr_core_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ID_W   = IDX_W + 1,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [NUM_CTX*NUM_SRC-1:0]   qualify,
  input  logic                         claimReq,
  input  logic [CTX_W-1:0]             claimCtx,
  input  logic                         completeReq,
  input  logic [ID_W-1:0]              completeId,
  output intr_core_pkg::core_strobe_t  strobe,
  output logic [IDX_W-1:0]             claimIdx,
  output logic [IDX_W-1:0]             completeIdx,
  output logic [ID_W-1:0]              claimId
);
  logic [NUM_SRC-1:0] row;
  logic               found;

  always_comb begin
    row = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (int'(claimCtx) == c) row = qualify[c*NUM_SRC +: NUM_SRC];
    end
    // scan downward so the lowest index wins
    found    = 1'b0;
    claimIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (row[i]) begin
        found    = 1'b1;
        claimIdx = IDX_W'(i);
      end
    end
    strobe.claimFire    = claimReq & found;
    strobe.completeFire = completeReq & (int'(completeId) < NUM_SRC);
    completeIdx         = completeId[IDX_W-1:0];
    claimId             = strobe.claimFire ? ID_W'(claimIdx) : '0;
  end
endmodule

// File: rtl/intr_claim_core.sv
module intr_claim_core #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ID_W   = IDX_W + 1,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic [NUM_SRC*PRIO_W-1:0]  srcPrio,
  input  logic [NUM_CTX*NUM_SRC-1:0] ctxEnable,
  input  logic [NUM_CTX*PRIO_W-1:0]  ctxThresh,
  input  logic                       claimReq,
  input  logic [CTX_W-1:0]           claimCtx,
  output logic [ID_W-1:0]            claimId,
  input  logic                       completeReq,
  input  logic [ID_W-1:0]            completeId,
  output logic [NUM_CTX-1:0]         irqOut
);
  intr_core_pkg::core_strobe_t strobe;
  logic [NUM_CTX*NUM_SRC-1:0]  qualify;
  logic [IDX_W-1:0]            claimIdx, completeIdx;
  logic [NUM_SRC-1:0]          pendingVec, claimedVec;

  intr_core_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_ctrl (
    .qualify(qualify), .claimReq(claimReq), .claimCtx(claimCtx),
    .completeReq(completeReq), .completeId(completeId), .strobe(strobe),
    .claimIdx(claimIdx), .completeIdx(completeIdx), .claimId(claimId)
  );

  intr_core_dp #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcPrio(srcPrio),
    .ctxEnable(ctxEnable), .ctxThresh(ctxThresh), .strobe(strobe),
    .claimIdx(claimIdx), .completeIdx(completeIdx), .qualify(qualify),
    .irqOut(irqOut), .pendingVec(pendingVec), .claimedVec(claimedVec)
  );
endmodule

// File: rtl/intr_claim_core_chk.sv
module intr_claim_core_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2,
  parameter int ID_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               claimReq,
  input logic [ID_W-1:0]    claimId,
  input logic               completeReq,
  input logic [ID_W-1:0]    completeId,
  input logic [NUM_CTX-1:0] irqOut,
  input logic [NUM_SRC-1:0] pendingVec,
  input logic [NUM_SRC-1:0] claimedVec
);
  p_src0_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    pendingVec[0] == 1'b0);

  p_irq_has_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> $past((pendingVec & ~claimedVec) != '0));

  p_claim_marks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (claimReq && claimId != '0) |=>
      (((claimedVec >> $past(claimId)) & 1) != 0) &&
      (((pendingVec >> $past(claimId)) & 1) == 0));

  p_empty_claim_r6: assert property (@(posedge clk) disable iff (!rstN)
    (claimReq && claimId == '0 && !completeReq) |=> $stable(claimedVec));

  p_complete_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (completeReq && int'(completeId) < NUM_SRC) |=>
      (((claimedVec >> $past(completeId)) & 1) == 0));

  p_bad_complete_r7: assert property (@(posedge clk) disable iff (!rstN)
    (completeReq && int'(completeId) >= NUM_SRC && !claimReq) |=> $stable(claimedVec));
endmodule

bind intr_claim_core intr_claim_core_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .claimReq(claimReq), .claimId(claimId),
  .completeReq(completeReq), .completeId(completeId), .irqOut(irqOut),
  .pendingVec(pendingVec), .claimedVec(claimedVec)
);

// File: tb/intr_claim_core_test.sv
`timescale 1ns/100ps
module intr_claim_core_test;
  localparam int NS = 8, NC = 2, PW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcLevel = '0;
  logic [NS*PW-1:0] srcPrio;
  logic [NC*NS-1:0] ctxEnable = '0;
  logic [NC*PW-1:0] ctxThresh = '0;
  logic          claimReq = 1'b0;
  logic [0:0]    claimCtx = '0;
  logic [3:0]    claimId;
  logic          completeReq = 1'b0;
  logic [3:0]    completeId = '0;
  logic [NC-1:0] irqOut;
  int nRun = 0, nFail = 0;
  logic [3:0] got;

  always #2 clk = ~clk;

  intr_claim_core #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) uut (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .srcPrio(srcPrio),
    .ctxEnable(ctxEnable), .ctxThresh(ctxThresh), .claimReq(claimReq),
    .claimCtx(claimCtx), .claimId(claimId), .completeReq(completeReq),
    .completeId(completeId), .irqOut(irqOut)
  );

  // priority of source i is i
  always_comb for (int i = 0; i < NS; i++) srcPrio[i*PW +: PW] = PW'(i);

  typedef struct packed {
    logic [7:0] lvl;
    logic [7:0] en;
    logic [2:0] thr;
    logic [3:0] expId;
    logic       expIrq;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'b0000_0110, 8'hFF, 3'd0, 4'd1, 1'b1},  // R2 simple
    '{8'b1111_0000, 8'hFF, 3'd4, 4'd5, 1'b1},  // R2 equal prio not above
    '{8'b1000_0000, 8'hFF, 3'd7, 4'd0, 1'b0},  // R9 top threshold blocks all
    '{8'b1111_1111, 8'hAA, 3'd2, 4'd3, 1'b1},  // R2 enable mask
    '{8'b0000_0001, 8'hFF, 3'd0, 4'd0, 1'b0},  // R1 source 0 ignored
    '{8'b1111_1110, 8'h00, 3'd0, 4'd0, 1'b0},  // R2 nothing enabled
    '{8'b1000_0100, 8'hFF, 3'd1, 4'd2, 1'b1}   // R4 lowest index wins
  };

  task automatic check(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek(input int ctx, output logic [3:0] id);
    claimCtx = 1'(ctx);
    claimReq = 1'b1;
    #0.5 id = claimId;
    claimReq = 1'b0;
    #0.5;
  endtask

  task automatic claim(input int ctx, output logic [3:0] id);
    claimCtx = 1'(ctx);
    claimReq = 1'b1;
    #0.5 id = claimId;
    tick();
    claimReq = 1'b0;
  endtask

  task automatic complete(input int id);
    completeId = 4'(id);
    completeReq = 1'b1;
    tick();
    completeReq = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    srcLevel = 8'hFE;
    ctxEnable = '1;
    @(negedge clk);
    tick();
    // R8: nothing pending or requested while in reset
    check("R8 irq in reset", int'(irqOut), 0);
    srcLevel = '0;
    rstN = 1'b1;
    tick();
    check("R8 irq after reset", int'(irqOut), 0);
    peek(0, got);
    check("R8 claim after reset", int'(got), 0);

    // table walk on context 0, context 1 disabled
    for (int v = 0; v < 7; v++) begin
      srcLevel = VEC[v].lvl;
      ctxEnable = {8'h00, VEC[v].en};
      ctxThresh = {3'd0, VEC[v].thr};
      tick();
      tick();
      check($sformatf("R3 vec%0d irq", v), int'(irqOut[0]), int'(VEC[v].expIrq));
      peek(0, got);
      check($sformatf("R4 vec%0d id", v), int'(got), int'(VEC[v].expId));
    end

    // claim / complete sequence
    srcLevel = 8'b0010_1000;
    ctxEnable = {8'b0000_1000, 8'hFF};
    ctxThresh = '0;
    tick();
    tick();
    check("R3 both irq", int'(irqOut), 3);
    claim(0, got);
    check("R4 claim ctx0", int'(got), 3);
    peek(0, got);
    check("R5 claimed source masked", int'(got), 5);
    peek(1, got);
    check("R5 masked for other ctx", int'(got), 0);
    tick();
    check("R3 irq1 drops", int'(irqOut[1]), 0);
    complete(3);
    peek(1, got);
    check("R7 complete releases", int'(got), 3);
    claim(1, got);
    check("R4 claim ctx1", int'(got), 3);
    complete(9);
    peek(1, got);
    check("R7 out of range ignored", int'(got), 0);
    complete(3);
    peek(1, got);
    check("R7 release again", int'(got), 3);

    // R6: empty claim changes nothing
    ctxThresh = {3'd7, 3'd0};
    claim(1, got);
    check("R6 empty claim id", int'(got), 0);
    ctxThresh = '0;
    peek(1, got);
    check("R6 state kept", int'(got), 3);

    // R1: level drop clears pending
    srcLevel = 8'b0010_0000;
    tick();
    peek(1, got);
    check("R1 level low", int'(got), 0);

    // R5: pending is resampled after the claim edge
    claim(0, got);
    check("R5 claim src5", int'(got), 5);
    peek(0, got);
    check("R5 no re-claim", int'(got), 0);
    complete(5);
    peek(0, got);
    check("R5 level resampled", int'(got), 5);

    // R3 latency: two edges after a rising level
    srcLevel = '0;
    tick();
    tick();
    check("R3 idle", int'(irqOut[0]), 0);
    srcLevel = 8'b0100_0000;
    tick();
    check("R3 first edge", int'(irqOut[0]), 0);
    tick();
    check("R3 second edge", int'(irqOut[0]), 1);

    // R9: priority-0 source under threshold 0
    srcLevel = 8'b0000_0001;
    tick();
    tick();
    check("R9 prio0 irq", int'(irqOut), 0);

    finish_run();
  end
endmodule